// File: doc/BRIEF.md
# I/Q Sample Serializer with Framing Strobe

This block takes parallel 16-bit receive samples with an in-phase (I) and a quadrature (Q) part and sends them out one bit per slot on low-speed serial lanes. A framing strobe runs beside the lanes. Each bit slot is one tick of a bit-rate clock enable input, `slot_tick`. The lane outputs, the strobe and a registered copy of the tick all change on the same clock edge. The physical output cells, differential drivers and clock generation sit outside this block.

There are two lane arrangements. In two-lane mode, I and Q leave side by side, each on its own lane. In one-lane mode, I and Q take turns on a single lane. The word length is 16 bits, or 12 bits taken from either end of the input sample. Four further choices are made per sample: bit order, which part goes first, which end the 12 bits come from, and the strobe style. The strobe style is either a one-slot start pulse or a half-period level that separates the first half of a sample from the second.

Input samples arrive through a valid/ready handshake. A new sample is taken on the last slot of the current one, so the stream has no gaps while data keeps coming. When no sample is waiting, the outputs fall low.

Top module: `iq_serializer`

## Requirements
- R1: While `rst_n` is low (asynchronous assertion), `lane_i`, `lane_q`, `strobe_o` and `bit_clk_en` are 0. They stay 0 in the first cycle after `rst_n` rises.
- R2: `in_ready` is high only in a cycle with `slot_tick` high, and only when the block is idle or is showing the last slot of a sample. A sample is accepted at the clock edge where `in_valid` and `in_ready` are both high. Its first slot appears on the outputs in the cycle that follows that edge.
- R3: Two-lane mode (`cfg_one_lane`=0): the I word goes out on `lane_i` and the Q word of the same sample goes out on `lane_q` in the same slots, one bit per tick. A sample lasts W slots.
- R4: One-lane mode (`cfg_one_lane`=1): both words go out back to back on `lane_i` over 2W slots. The Q word goes first when `cfg_q_first`=1, and the I word goes first when it is 0. `lane_q` stays 0 throughout.
- R5: `cfg_lsb_first`=0 sends each word most significant kept bit first. `cfg_lsb_first`=1 sends it least significant kept bit first.
- R6: `cfg_word12`=1 sets W=12, and `cfg_word12`=0 sets W=16. In 12-bit mode, `cfg_keep_low`=0 sends input bits [15:4] and `cfg_keep_low`=1 sends input bits [11:0].
- R7: With `cfg_level_strobe`=0, `strobe_o` is high only in slot 0 of each sample. It is low in every other slot.
- R8: With `cfg_level_strobe`=1, `strobe_o` is high in slots 0 to P/2-1 and low in slots P/2 to P-1. Here P is W in two-lane mode and 2W in one-lane mode.
- R9: If `in_valid` is high on the last slot, the next sample's slot 0 follows in the very next slot. The strobe rises again there.
- R10: If no sample is accepted on the last slot, `lane_i`, `lane_q` and `strobe_o` go to 0 at the next tick. They stay 0 until a sample is accepted.
- R11: The configuration inputs are captured only when a sample is accepted. Changing them during a sample does not alter that sample's output.
- R12: `bit_clk_en` is `slot_tick` delayed by one clock. The lanes and the strobe change only at edges after which `bit_clk_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_tick | input | 1 | Bit-rate clock enable, one pulse per slot |
| in_valid | input | 1 | Sample available |
| in_ready | output | 1 | Sample taken at this edge when in_valid is high |
| in_i | input | 16 | In-phase sample |
| in_q | input | 16 | Quadrature sample |
| cfg_one_lane | input | 1 | 1: I and Q share lane_i |
| cfg_word12 | input | 1 | 1: 12-bit words |
| cfg_keep_low | input | 1 | 12-bit mode: 1 keeps bits [11:0], 0 keeps bits [15:4] |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_q_first | input | 1 | One-lane mode: 1 sends Q first |
| cfg_level_strobe | input | 1 | 1: half-period level strobe, 0: one-slot pulse |
| lane_i | output | 1 | Serial lane for I, or for both parts in one-lane mode |
| lane_q | output | 1 | Serial lane for Q |
| strobe_o | output | 1 | Framing strobe |
| bit_clk_en | output | 1 | Registered slot tick, aligned with lane changes |

## Verification
The sensitive cycle is the last slot of a sample, where a handshake can complete at the same edge that would otherwise shift the lanes or send the block idle. A back-to-back test holds `in_valid` high across a sample boundary and swaps the data right after the first acceptance. It then checks three things: `in_ready` is low in every slot except the last, the next slot already carries the new sample's first bit, and the strobe rises again there. A second case flips every configuration input while a sample is in progress. That sample must still match the values computed from the configuration captured at acceptance.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

  // Per-sample configuration, captured at acceptance.
  typedef struct packed {
    logic one_lane;
    logic word12;
    logic keep_low;
    logic lsb_first;
    logic q_first;
    logic level_strobe;
  } iqs_cfg_t;

endpackage

// File: rtl/iqs_rst_sync.sv
module iqs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/iqs_word_prep.sv
// Truncates and reorders one sample part. The result is left-justified:
// bit SAMPLE_W-1 is the first bit to leave the lane.
module iqs_word_prep #(
  parameter int SAMPLE_W = 16,
  parameter int SHORT_W  = 12
) (
  input  logic [SAMPLE_W-1:0] raw,
  input  logic                word12,
  input  logic                keep_low,
  input  logic                lsb_first,
  output logic [SAMPLE_W-1:0] word
);

  localparam int DROP_W = SAMPLE_W - SHORT_W;

  logic [SAMPLE_W-1:0] trunc;
  logic [SAMPLE_W-1:0] rev;

  always_comb begin
    trunc = raw;
    if (word12) begin
      if (keep_low) begin
        trunc = {raw[SHORT_W-1:0], {DROP_W{1'b0}}};
      end else begin
        trunc = {raw[SAMPLE_W-1:DROP_W], {DROP_W{1'b0}}};
      end
    end
    for (int b = 0; b < SAMPLE_W; b++) begin
      rev[b] = trunc[SAMPLE_W-1-b];
    end
    if (!lsb_first) begin
      word = trunc;
    end else if (word12) begin
      word = rev << DROP_W;
    end else begin
      word = rev;
    end
  end

endmodule

// File: rtl/iqs_shift_lane.sv
module iqs_shift_lane #(
  parameter int LEN = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic           clear,
  input  logic [LEN-1:0] load_val,
  output logic           bit_o
);

  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] sr_d;
  logic           sr_en;

  always_comb begin
    sr_d = sr_q;
    if (clear) begin
      sr_d = '0;
    end else if (load) begin
      sr_d = load_val;
    end else if (shift) begin
      sr_d = {sr_q[LEN-2:0], 1'b0};
    end
  end

  assign sr_en = clear | load | shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign bit_o = sr_q[LEN-1];

  // R2
  lane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clear |=> bit_o == $past(load_val[LEN-1]));

  // R10
  lane_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !bit_o);

endmodule

// File: rtl/iqs_frame_ctl.sv
module iqs_frame_ctl
  import iqs_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHORT_W  = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     slot_tick,
  input  logic     in_valid,
  input  iqs_cfg_t cfg_in,
  output logic     in_ready,
  output logic     load_o,
  output logic     shift_o,
  output logic     clear_o,
  output logic     active_o,
  output logic     strobe_o,
  output iqs_cfg_t cfg_o
);

  localparam int PER_W = $clog2(2 * SAMPLE_W) + 1;

  logic [PER_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [PER_W-1:0] word_len, period, last_slot, half_len;
  logic             active_q, active_d;
  logic             strobe_q, strobe_d;
  iqs_cfg_t         cfg_q, cfg_d;
  logic             at_end;
  logic             load, shift, clear;

  // Period geometry of the sample in flight.
  always_comb begin
    word_len  = cfg_q.word12 ? PER_W'(SHORT_W) : PER_W'(SAMPLE_W);
    period    = cfg_q.one_lane ? (word_len << 1) : word_len;
    last_slot = period - PER_W'(1);
    half_len  = period >> 1;
    cnt_inc   = cnt_q + PER_W'(1);
  end

  assign at_end   = active_q && (cnt_q == last_slot);
  assign in_ready = slot_tick && (!active_q || at_end);
  assign load     = in_ready && in_valid;
  assign shift    = slot_tick && active_q && !at_end;
  assign clear    = slot_tick && at_end && !in_valid;

  // Next state
  always_comb begin
    cnt_d    = cnt_q;
    active_d = active_q;
    strobe_d = strobe_q;
    cfg_d    = cfg_q;
    if (load) begin
      cnt_d    = '0;
      active_d = 1'b1;
      strobe_d = 1'b1;
      cfg_d    = cfg_in;
    end else if (shift) begin
      cnt_d    = cnt_inc;
      strobe_d = cfg_q.level_strobe && (cnt_inc < half_len);
    end else if (clear) begin
      cnt_d    = '0;
      active_d = 1'b0;
      strobe_d = 1'b0;
    end
  end

  // State registers, enabled once per slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      strobe_q <= 1'b0;
      cfg_q    <= '0;
    end else if (slot_tick) begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      strobe_q <= strobe_d;
      cfg_q    <= cfg_d;
    end
  end

  assign load_o   = load;
  assign shift_o  = shift;
  assign clear_o  = clear;
  assign active_o = active_q;
  assign strobe_o = strobe_q;
  assign cfg_o    = cfg_q;

  // R7
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !cfg_q.level_strobe && (cnt_q != '0) |-> !strobe_q);

  // R8
  level_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && cfg_q.level_strobe |-> strobe_q == (cnt_q < half_len));

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> cnt_q <= last_slot);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> $stable(cnt_q) && $stable(strobe_q) && $stable(active_q));

endmodule

// File: rtl/iq_serializer.sv
module iq_serializer
  import iqs_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHORT_W  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_tick,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_i,
  input  logic [SAMPLE_W-1:0] in_q,
  input  logic                cfg_one_lane,
  input  logic                cfg_word12,
  input  logic                cfg_keep_low,
  input  logic                cfg_lsb_first,
  input  logic                cfg_q_first,
  input  logic                cfg_level_strobe,
  output logic                lane_i,
  output logic                lane_q,
  output logic                strobe_o,
  output logic                bit_clk_en
);

  localparam int DROP_W   = SAMPLE_W - SHORT_W;
  localparam int LANE_LEN = 2 * SAMPLE_W;
  localparam int N_PART   = 2;

  logic                rst_sync_n;
  iqs_cfg_t            cfg_in, cfg_cur;
  logic                load, shift, clear, active;
  logic [SAMPLE_W-1:0] raw_v  [N_PART];
  logic [SAMPLE_W-1:0] word_v [N_PART];
  logic [LANE_LEN-1:0] load_v [N_PART];
  logic                lane_bit [N_PART];
  logic [SAMPLE_W-1:0] first_w, second_w;
  logic                bce_q;

  iqs_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cfg_in = '{one_lane:     cfg_one_lane,
                    word12:       cfg_word12,
                    keep_low:     cfg_keep_low,
                    lsb_first:    cfg_lsb_first,
                    q_first:      cfg_q_first,
                    level_strobe: cfg_level_strobe};

  assign raw_v[0] = in_i;
  assign raw_v[1] = in_q;

  iqs_frame_ctl #(
    .SAMPLE_W (SAMPLE_W),
    .SHORT_W  (SHORT_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slot_tick (slot_tick),
    .in_valid  (in_valid),
    .cfg_in    (cfg_in),
    .in_ready  (in_ready),
    .load_o    (load),
    .shift_o   (shift),
    .clear_o   (clear),
    .active_o  (active),
    .strobe_o  (strobe_o),
    .cfg_o     (cfg_cur)
  );

  generate
    for (genvar g = 0; g < N_PART; g++) begin : g_prep
      iqs_word_prep #(
        .SAMPLE_W (SAMPLE_W),
        .SHORT_W  (SHORT_W)
      ) u_prep (
        .raw       (raw_v[g]),
        .word12    (cfg_in.word12),
        .keep_low  (cfg_in.keep_low),
        .lsb_first (cfg_in.lsb_first),
        .word      (word_v[g])
      );
    end
  endgenerate

  // Lane load images, built from the configuration seen at acceptance.
  always_comb begin
    first_w  = cfg_in.q_first ? word_v[1] : word_v[0];
    second_w = cfg_in.q_first ? word_v[0] : word_v[1];
    if (cfg_in.one_lane) begin
      load_v[1] = '0;
      if (cfg_in.word12) begin
        load_v[0] = {first_w[SAMPLE_W-1 -: SHORT_W],
                     second_w[SAMPLE_W-1 -: SHORT_W],
                     {(2 * DROP_W){1'b0}}};
      end else begin
        load_v[0] = {first_w, second_w};
      end
    end else begin
      load_v[0] = {word_v[0], {SAMPLE_W{1'b0}}};
      load_v[1] = {word_v[1], {SAMPLE_W{1'b0}}};
    end
  end

  generate
    for (genvar g = 0; g < N_PART; g++) begin : g_lane
      iqs_shift_lane #(
        .LEN (LANE_LEN)
      ) u_lane (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .load     (load),
        .shift    (shift),
        .clear    (clear),
        .load_val (load_v[g]),
        .bit_o    (lane_bit[g])
      );
    end
  endgenerate

  assign lane_i = lane_bit[0];
  assign lane_q = lane_bit[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bce_q <= 1'b0;
    end else begin
      bce_q <= slot_tick;
    end
  end

  assign bit_clk_en = bce_q;

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !active |-> !lane_i && !lane_q && !strobe_o);

  // R4
  q_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active && cfg_cur.one_lane |-> !lane_q);

  // R2
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && in_ready |=> strobe_o && bit_clk_en && active);

  // R12
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bit_clk_en |-> $stable(lane_i) && $stable(lane_q) && $stable(strobe_o));

endmodule

// File: tb/iq_serializer_tb.sv
`timescale 1ns/1ps
module iq_serializer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        slot_tick;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_i, in_q;
  logic        cfg_one_lane, cfg_word12, cfg_keep_low;
  logic        cfg_lsb_first, cfg_q_first, cfg_level_strobe;
  logic        lane_i, lane_q, strobe_o, bit_clk_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int tick_gap = 1;
  int tick_cnt = 0;
  logic exp_bce = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tick_cnt <= (tick_cnt >= tick_gap - 1) ? 0 : tick_cnt + 1;
    exp_bce  <= slot_tick;
  end
  assign slot_tick = (tick_cnt == 0);

  iq_serializer u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .slot_tick        (slot_tick),
    .in_valid         (in_valid),
    .in_ready         (in_ready),
    .in_i             (in_i),
    .in_q             (in_q),
    .cfg_one_lane     (cfg_one_lane),
    .cfg_word12       (cfg_word12),
    .cfg_keep_low     (cfg_keep_low),
    .cfg_lsb_first    (cfg_lsb_first),
    .cfg_q_first      (cfg_q_first),
    .cfg_level_strobe (cfg_level_strobe),
    .lane_i           (lane_i),
    .lane_q           (lane_q),
    .strobe_o         (strobe_o),
    .bit_clk_en       (bit_clk_en)
  );

  // cfg field order: {one_lane, word12, keep_low, lsb_first, q_first, level}
  localparam logic [37:0] VEC [9] = '{
    {6'b000000, 16'hA5C3, 16'h1E7F},
    {6'b000001, 16'h8001, 16'h7FFE},
    {6'b000100, 16'h1234, 16'hABCD},
    {6'b010000, 16'hF0A5, 16'h0FED},
    {6'b011101, 16'h3C96, 16'hC369},
    {6'b100000, 16'hDEAD, 16'hBEEF},
    {6'b100011, 16'h0F0F, 16'h5A5A},
    {6'b110111, 16'h1357, 16'h2468},
    {6'b110001, 16'hFFFF, 16'h0001}
  };

  task automatic chk(input logic ok, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", what);
    end
  endtask

  function automatic logic pick(input logic [15:0] x, input logic w12,
                                input logic klow, input logic lsb, input int j);
    logic [15:0] t;
    int w;
    w = w12 ? 12 : 16;
    t = x;
    if (w12) t = klow ? {4'b0, x[11:0]} : {4'b0, x[15:4]};
    return t[lsb ? j : (w - 1 - j)];
  endfunction

  function automatic int period_of(input logic [5:0] c);
    int w;
    w = c[4] ? 12 : 16;
    return c[5] ? 2 * w : w;
  endfunction

  // Expected {lane_i, lane_q, strobe} for slot k, from the requirements.
  function automatic logic [2:0] exp_slot(input logic [5:0] c, input logic [15:0] vi,
                                          input logic [15:0] vq, input int k);
    int w, p, j;
    logic li, lq, st;
    logic [15:0] f, s;
    w  = c[4] ? 12 : 16;
    p  = period_of(c);
    j  = k % w;
    f  = c[1] ? vq : vi;
    s  = c[1] ? vi : vq;
    if (c[5]) begin
      li = pick((k < w) ? f : s, c[4], c[3], c[2], j);
      lq = 1'b0;
    end else begin
      li = pick(vi, c[4], c[3], c[2], j);
      lq = pick(vq, c[4], c[3], c[2], j);
    end
    st = c[0] ? (k < p / 2) : (k == 0);
    return {li, lq, st};
  endfunction

  function automatic string tags(input logic [5:0] c);
    return $sformatf("%s %s %s %s", c[5] ? "R4" : "R3", c[4] ? "R6" : "R3",
                     c[2] ? "R5" : "R5", c[0] ? "R8" : "R7");
  endfunction

  task automatic drive_cfg(input logic [5:0] c);
    {cfg_one_lane, cfg_word12, cfg_keep_low, cfg_lsb_first, cfg_q_first, cfg_level_strobe} = c;
  endtask

  task automatic run_vec(input logic [37:0] v, input int gap, input bit scramble);
    logic [5:0]  c;
    logic [15:0] vi, vq;
    logic [2:0]  got, exp, last;
    int p;
    c  = v[37:32];
    vi = v[31:16];
    vq = v[15:0];
    p  = period_of(c);
    tick_gap = gap;
    @(negedge clk);
    drive_cfg(c);
    in_i = vi;
    in_q = vq;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    last = 3'b000;
    for (int k = 0; k < p; k++) begin
      @(negedge clk);
      while (!bit_clk_en) begin
        got = {lane_i, lane_q, strobe_o};
        chk(got == last && !in_ready,
            $sformatf("R12 R2 hold between ticks got=%b ready=%b exp=%b ready=0", got, in_ready, last));
        @(negedge clk);
      end
      if (k == 0) begin
        in_valid = 1'b0;
        if (scramble) drive_cfg(~c);
      end
      got = {lane_i, lane_q, strobe_o};
      exp = exp_slot(c, vi, vq, k);
      chk(got == exp, $sformatf("%s%s cfg=%b slot %0d got=%b exp=%b",
                                tags(c), scramble ? " R11" : "", c, k, got, exp));
      last = got;
    end
    @(negedge clk);
    while (!bit_clk_en) @(negedge clk);
    got = {lane_i, lane_q, strobe_o};
    chk(got == 3'b000, $sformatf("R10 idle after sample got=%b exp=000", got));
    drive_cfg(c);
  endtask

  initial begin
    logic [2:0] got, exp;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_i = '0;
    in_q = '0;
    drive_cfg(6'b000000);
    repeat (3) @(negedge clk);
    got = {lane_i, lane_q, strobe_o};
    chk(got == 3'b000 && !bit_clk_en,
        $sformatf("R1 in reset got=%b bce=%b exp=000 bce=0", got, bit_clk_en));
    rst_n = 1'b1;
    @(negedge clk);
    got = {lane_i, lane_q, strobe_o};
    chk(got == 3'b000 && !bit_clk_en,
        $sformatf("R1 after release got=%b bce=%b exp=000 bce=0", got, bit_clk_en));
    repeat (3) @(negedge clk);

    // Vector table
    for (int n = 0; n < 9; n++) run_vec(VEC[n], 1, 1'b0);

    // Sparse ticks
    run_vec(VEC[1], 3, 1'b0);
    run_vec(VEC[7], 2, 1'b0);

    // R12: bit_clk_en follows slot_tick by one clock
    tick_gap = 3;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      chk(bit_clk_en == exp_bce,
          $sformatf("R12 bit_clk_en got=%b exp=%b", bit_clk_en, exp_bce));
    end
    tick_gap = 1;
    repeat (3) @(negedge clk);

    // R9: back-to-back samples, handshake on the last slot
    @(negedge clk);
    drive_cfg(6'b000000);
    in_i = 16'h8421;
    in_q = 16'h0F0F;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      got = {lane_i, lane_q, strobe_o};
      exp = exp_slot(6'b000000, 16'h8421, 16'h0F0F, k);
      chk(got == exp, $sformatf("R9 R3 first sample slot %0d got=%b exp=%b", k, got, exp));
      chk(in_ready == (k == 15),
          $sformatf("R2 ready in slot %0d got=%b exp=%b", k, in_ready, k == 15));
      if (k == 0) begin
        in_i = 16'h7BDE;
        in_q = 16'hF00F;
      end
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      got = {lane_i, lane_q, strobe_o};
      exp = exp_slot(6'b000000, 16'h7BDE, 16'hF00F, k);
      chk(got == exp, $sformatf("R9 second sample slot %0d got=%b exp=%b", k, got, exp));
    end
    @(negedge clk);
    got = {lane_i, lane_q, strobe_o};
    chk(got == 3'b000, $sformatf("R10 idle after pair got=%b exp=000", got));
    in_i = 16'hFFFF;
    in_q = 16'hFFFF;
    repeat (4) @(negedge clk);
    got = {lane_i, lane_q, strobe_o};
    chk(got == 3'b000, $sformatf("R10 idle with data but no valid got=%b exp=000", got));

    // R11: configuration flipped mid-sample
    run_vec(VEC[0], 1, 1'b1);
    run_vec(VEC[6], 1, 1'b1);

    // R1: asynchronous reset during a sample
    @(negedge clk);
    drive_cfg(6'b000001);
    in_i = 16'hFFFF;
    in_q = 16'hFFFF;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    got = {lane_i, lane_q, strobe_o};
    chk(got == 3'b000 && !bit_clk_en,
        $sformatf("R1 async reset mid-sample got=%b bce=%b exp=000 bce=0", got, bit_clk_en));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    got = {lane_i, lane_q, strobe_o};
    chk(got == 3'b000, $sformatf("R1 after second release got=%b exp=000", got));

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule